// File: doc/BRIEF.md
# Consumer Set Predictor

This block sits beside a directory controller in a shared-memory multiprocessor. It guesses which nodes will read a cache block once its current producer has stopped writing it. For each tracked block it keeps a short register of sharing history. Each directory write request pushes one pair into that register. The pair holds the vector of nodes that read the previous value and the ID of the node that is now writing. The history, with the block index folded in by XOR, forms a signature. That signature selects an entry of a small set-associative table, and each entry holds one 2-bit confidence counter per node.

The table learns at write time. The sharer vector that arrives with a write is the true consumer set of the value it replaces, so the entry keyed by the block's history from before that write is trained with it. The block makes no guess when a write arrives. It guesses when a downgrade that the predictor started reaches the directory for the block. It looks up the block's current history and reports every node whose counter shows confidence. Sending the block to those nodes is done by other logic.

Top module: `consumer_set_predictor`

## Requirements
- R1: During and after reset `predValid` and `predSet` are 0, every history register is all zeros and the table holds no valid entry, so a downgrade right after reset yields an empty prediction.
- R2: A write to block b shifts block b's history left by one pair of NODES+ID_W bits and places {wrSharers, wrWriter} in the low bits (writer ID in bits [ID_W-1:0]). The oldest pair drops out. Histories of other blocks do not change.
- R3: The signature of block b is its history XOR the block index zero-extended. The table set is the low SET_W bits of the signature, and the full signature is the tag.
- R4: Each write looks up the signature of the block's history from before the write. On a hit, the counter of each node set in `wrSharers` rises by one and saturates at 3. Every other node's counter falls by one and saturates at 0.
- R5: On a training miss a new entry is written with counters at 2 for the nodes in `wrSharers` and 0 for the others. It goes into the lowest-numbered invalid way of the set. If the set is full it goes into the way named by that set's round-robin pointer, and the pointer then advances by one modulo WAYS.
- R6: A downgrade on block b raises `predValid` one cycle later. `predSet` then has bit n set exactly when the entry matching block b's current signature exists and node n's counter is 2 or more. A miss gives an all-zero `predSet`.
- R7: A cycle without a downgrade leaves `predValid` low and `predSet` zero in the next cycle, whether or not a write arrived.
- R8: When a write and a downgrade arrive in the same cycle, the prediction uses the history and table contents as they were before that write, including when both name the same block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Directory write request this cycle |
| wrBlock | input | ADDR_W | Tracked block index of the write |
| wrWriter | input | ID_W | Node ID of the writer |
| wrSharers | input | NODES | Nodes holding the block just before the write |
| dgValid | input | 1 | Predictor-initiated downgrade reached the directory |
| dgBlock | input | ADDR_W | Tracked block index of the downgrade |
| predValid | output | 1 | Prediction valid (one cycle after `dgValid`) |
| predSet | output | NODES | Predicted consumer vector |

## Verification
Training on a write and prediction on a downgrade can happen in the same cycle, and they can name the same block or blocks whose signatures fall in the same set. The bench provokes this with directed cycles that carry both a write and a downgrade for one block whose entry is about to change. It also uses a random phase that mixes both kinds of event over a few blocks and a small pool of sharer patterns. A reference model kept in plain arrays computes the prediction from the state before the edge and applies the training after it. The outputs are compared with the model every cycle.

// File: rtl/csp_pkg.sv
package csp_pkg;

  typedef struct packed {
    logic appendHist;
    logic bumpEntry;
    logic allocEntry;
    logic issuePred;
  } cspStrobe_t;

  function automatic logic [1:0] satUp(input logic [1:0] v);
    return (v == 2'd3) ? v : v + 2'd1;
  endfunction

  function automatic logic [1:0] satDown(input logic [1:0] v);
    return (v == 2'd0) ? v : v - 2'd1;
  endfunction

endpackage

// File: rtl/csp_way_match.sv
module csp_way_match #(
  parameter int WAYS  = 4,
  parameter int SIG_W = 40,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][SIG_W-1:0] tagRow,
  input  logic [WAYS-1:0]            validRow,
  input  logic [SIG_W-1:0]           sig,
  output logic                       hit,
  output logic [WAY_W-1:0]           hitWay
);

  logic [WAYS-1:0] matchVec;

  for (genvar w = 0; w < WAYS; w++) begin : gWay
    assign matchVec[w] = validRow[w] && (tagRow[w] == sig);
  end

  always_comb begin
    hit    = |matchVec;
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (matchVec[w]) hitWay = WAY_W'(w);
    end
  end

endmodule

// File: rtl/csp_ctrl.sv
module csp_ctrl
  import csp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       dgValid,
  input  logic       trnHit,
  output cspStrobe_t strb,
  output logic       predValid
);

  always_comb begin
    strb            = '0;
    strb.appendHist = wrValid;
    strb.bumpEntry  = wrValid && trnHit;
    strb.allocEntry = wrValid && !trnHit;
    strb.issuePred  = dgValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) predValid <= 1'b0;
    else       predValid <= strb.issuePred;
  end

endmodule

// File: rtl/csp_datapath.sv
module csp_datapath
  import csp_pkg::*;
#(
  parameter int NODES  = 16,
  parameter int PAIRS  = 2,
  parameter int BLOCKS = 16,
  parameter int SETS   = 8,
  parameter int WAYS   = 4,
  localparam int ID_W   = $clog2(NODES),
  localparam int ADDR_W = $clog2(BLOCKS),
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int PAIR_W = NODES + ID_W,
  localparam int SIG_W  = PAIRS * PAIR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  cspStrobe_t        strb,
  input  logic [ADDR_W-1:0] wrBlock,
  input  logic [ID_W-1:0]   wrWriter,
  input  logic [NODES-1:0]  wrSharers,
  input  logic [ADDR_W-1:0] dgBlock,
  output logic              trnHit,
  output logic [NODES-1:0]  predSet
);

  logic [BLOCKS-1:0][SIG_W-1:0]                histReg;
  logic [SETS-1:0][WAYS-1:0][SIG_W-1:0]        tagArr;
  logic [SETS-1:0][WAYS-1:0]                   validArr;
  logic [SETS-1:0][WAYS-1:0][NODES-1:0][1:0]   ctrArr;
  logic [SETS-1:0][WAY_W-1:0]                  rrPtr;

  logic [SIG_W-1:0] trnSig, predSig;
  logic [SET_W-1:0] trnSetIdx, predSetIdx;
  logic [WAY_W-1:0] trnHitWay, predWay, victimWay;
  logic             predHit, useRr;
  logic [NODES-1:0] predRaw;

  // signatures: history folded with the block index
  assign trnSig     = histReg[wrBlock] ^ SIG_W'(wrBlock);
  assign predSig    = histReg[dgBlock] ^ SIG_W'(dgBlock);
  assign trnSetIdx  = trnSig[SET_W-1:0];
  assign predSetIdx = predSig[SET_W-1:0];

  csp_way_match #(.WAYS(WAYS), .SIG_W(SIG_W)) uTrnMatch (
    .tagRow  (tagArr[trnSetIdx]),
    .validRow(validArr[trnSetIdx]),
    .sig     (trnSig),
    .hit     (trnHit),
    .hitWay  (trnHitWay)
  );

  csp_way_match #(.WAYS(WAYS), .SIG_W(SIG_W)) uPredMatch (
    .tagRow  (tagArr[predSetIdx]),
    .validRow(validArr[predSetIdx]),
    .sig     (predSig),
    .hit     (predHit),
    .hitWay  (predWay)
  );

  // victim: lowest invalid way, else the set's round-robin pointer
  always_comb begin
    victimWay = rrPtr[trnSetIdx];
    useRr     = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!validArr[trnSetIdx][w]) begin
        victimWay = WAY_W'(w);
        useRr     = 1'b0;
      end
    end
  end

  always_comb begin
    for (int n = 0; n < NODES; n++) begin
      predRaw[n] = predHit && ctrArr[predSetIdx][predWay][n][1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histReg <= '0;
    end else if (strb.appendHist) begin
      histReg[wrBlock] <= (histReg[wrBlock] << PAIR_W)
                          | SIG_W'({wrSharers, wrWriter});
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagArr   <= '0;
      validArr <= '0;
      ctrArr   <= '0;
      rrPtr    <= '0;
    end else if (strb.bumpEntry) begin
      for (int n = 0; n < NODES; n++) begin
        ctrArr[trnSetIdx][trnHitWay][n] <= wrSharers[n]
          ? satUp(ctrArr[trnSetIdx][trnHitWay][n])
          : satDown(ctrArr[trnSetIdx][trnHitWay][n]);
      end
    end else if (strb.allocEntry) begin
      validArr[trnSetIdx][victimWay] <= 1'b1;
      tagArr[trnSetIdx][victimWay]   <= trnSig;
      for (int n = 0; n < NODES; n++) begin
        ctrArr[trnSetIdx][victimWay][n] <= wrSharers[n] ? 2'd2 : 2'd0;
      end
      if (useRr) rrPtr[trnSetIdx] <= rrPtr[trnSetIdx] + WAY_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) predSet <= '0;
    else       predSet <= strb.issuePred ? predRaw : '0;
  end

endmodule

// File: rtl/consumer_set_predictor.sv
module consumer_set_predictor
  import csp_pkg::*;
#(
  parameter int NODES  = 16,
  parameter int PAIRS  = 2,
  parameter int BLOCKS = 16,
  parameter int SETS   = 8,
  parameter int WAYS   = 4,
  localparam int ID_W   = $clog2(NODES),
  localparam int ADDR_W = $clog2(BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrBlock,
  input  logic [ID_W-1:0]   wrWriter,
  input  logic [NODES-1:0]  wrSharers,
  input  logic              dgValid,
  input  logic [ADDR_W-1:0] dgBlock,
  output logic              predValid,
  output logic [NODES-1:0]  predSet
);

  cspStrobe_t strb;
  logic       trnHit;

  csp_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrValid  (wrValid),
    .dgValid  (dgValid),
    .trnHit   (trnHit),
    .strb     (strb),
    .predValid(predValid)
  );

  csp_datapath #(
    .NODES(NODES), .PAIRS(PAIRS), .BLOCKS(BLOCKS), .SETS(SETS), .WAYS(WAYS)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrBlock  (wrBlock),
    .wrWriter (wrWriter),
    .wrSharers(wrSharers),
    .dgBlock  (dgBlock),
    .trnHit   (trnHit),
    .predSet  (predSet)
  );

endmodule

// File: rtl/csp_checker.sv
module csp_checker
  import csp_pkg::*;
#(
  parameter int NODES = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrValid,
  input logic             dgValid,
  input logic             predValid,
  input logic [NODES-1:0] predSet,
  input cspStrobe_t       strb
);

  assert_pred_follows_dg_R6: assert property (@(posedge clk) disable iff (!rstN)
    dgValid |=> predValid);

  assert_quiet_without_dg_R7: assert property (@(posedge clk) disable iff (!rstN)
    !dgValid |=> (!predValid && predSet == '0));

  assert_write_trains_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (strb.bumpEntry || strb.allocEntry));

  assert_single_update_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.bumpEntry, strb.allocEntry}));

  assert_history_on_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.appendHist |-> wrValid);

endmodule

bind consumer_set_predictor csp_checker #(.NODES(NODES)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .wrValid  (wrValid),
  .dgValid  (dgValid),
  .predValid(predValid),
  .predSet  (predSet),
  .strb     (strb)
);

// File: tb/consumer_set_predictor_test.sv
`timescale 1ns/1ps
module consumer_set_predictor_test;

  localparam int NODES = 16, PAIRS = 2, BLOCKS = 16, SETS = 8, WAYS = 4;
  localparam int ID_W = $clog2(NODES), ADDR_W = $clog2(BLOCKS);
  localparam int SIG_W = PAIRS * (NODES + ID_W);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrValid = 1'b0;
  logic [ADDR_W-1:0] wrBlock = '0;
  logic [ID_W-1:0]   wrWriter = '0;
  logic [NODES-1:0]  wrSharers = '0;
  logic              dgValid = 1'b0;
  logic [ADDR_W-1:0] dgBlock = '0;
  logic              predValid;
  logic [NODES-1:0]  predSet;

  int vecCount = 0;
  int missCount = 0;

  always #2.5 clk = ~clk;

  consumer_set_predictor uut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrBlock(wrBlock),
    .wrWriter(wrWriter), .wrSharers(wrSharers), .dgValid(dgValid),
    .dgBlock(dgBlock), .predValid(predValid), .predSet(predSet)
  );

  // reference model state
  logic [SIG_W-1:0] mHist [BLOCKS];
  logic [SIG_W-1:0] mTag  [SETS][WAYS];
  bit               mValid[SETS][WAYS];
  int               mCtr  [SETS][WAYS][NODES];
  int               mRr   [SETS];

  function automatic int findWay(input logic [SIG_W-1:0] sig);
    int s = int'(sig[2:0]);
    for (int w = 0; w < WAYS; w++)
      if (mValid[s][w] && mTag[s][w] == sig) return w;
    return -1;
  endfunction

  task automatic modelReset();
    for (int b = 0; b < BLOCKS; b++) mHist[b] = '0;
    for (int s = 0; s < SETS; s++) begin
      mRr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        mValid[s][w] = 0;
        mTag[s][w] = '0;
        for (int n = 0; n < NODES; n++) mCtr[s][w][n] = 0;
      end
    end
  endtask

  task automatic compare(input bit expV, input logic [NODES-1:0] expS, input string req);
    vecCount++;
    if (predValid !== expV || predSet !== expS) begin
      missCount++;
      $display("FAIL %s: predValid=%0b predSet=%h, expected predValid=%0b predSet=%h",
               req, predValid, predSet, expV, expS);
    end
  endtask

  task automatic cycle(input bit wv, input int wb, input int ww, input logic [NODES-1:0] ws,
                       input bit dv, input int db, input string req);
    logic [SIG_W-1:0] sig;
    logic [NODES-1:0] expS;
    int s, w;
    @(negedge clk);
    wrValid = wv; wrBlock = ADDR_W'(wb); wrWriter = ID_W'(ww); wrSharers = ws;
    dgValid = dv; dgBlock = ADDR_W'(db);
    // prediction from the state before the edge (R8)
    expS = '0;
    if (dv) begin
      sig = mHist[db] ^ SIG_W'(db);
      w = findWay(sig);
      s = int'(sig[2:0]);
      if (w >= 0)
        for (int n = 0; n < NODES; n++) expS[n] = (mCtr[s][w][n] >= 2);
    end
    // training and history update
    if (wv) begin
      sig = mHist[wb] ^ SIG_W'(wb);
      s = int'(sig[2:0]);
      w = findWay(sig);
      if (w >= 0) begin
        for (int n = 0; n < NODES; n++)
          if (ws[n]) mCtr[s][w][n] = (mCtr[s][w][n] == 3) ? 3 : mCtr[s][w][n] + 1;
          else       mCtr[s][w][n] = (mCtr[s][w][n] == 0) ? 0 : mCtr[s][w][n] - 1;
      end else begin
        w = -1;
        for (int k = WAYS - 1; k >= 0; k--) if (!mValid[s][k]) w = k;
        if (w < 0) begin
          w = mRr[s];
          mRr[s] = (mRr[s] + 1) % WAYS;
        end
        mValid[s][w] = 1;
        mTag[s][w] = sig;
        for (int n = 0; n < NODES; n++) mCtr[s][w][n] = ws[n] ? 2 : 0;
      end
      mHist[wb] = (mHist[wb] << (NODES + ID_W)) | SIG_W'({ws, ID_W'(ww)});
    end
    @(posedge clk);
    #1.25;
    compare(dv, expS, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    missCount++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    modelReset();
    // R1: outputs held at zero in reset
    repeat (3) begin
      @(posedge clk); #1.25;
      compare(1'b0, '0, "R1");
    end
    @(negedge clk); rstN = 1'b1;
    // R1: empty table after reset gives empty prediction on every block
    for (int b = 0; b < BLOCKS; b++) cycle(0, 0, 0, '0, 1, b, "R1");
    // R7: writes alone never produce a prediction
    cycle(1, 3, 5, 16'h0000, 0, 0, "R7");
    cycle(1, 3, 5, 16'h0050, 0, 0, "R7");
    // R4: repeat a pattern until it hits and saturates, then predict
    for (int i = 0; i < 5; i++) cycle(1, 3, 5, 16'h0050, 0, 0, "R4");
    cycle(0, 0, 0, '0, 1, 3, "R4");
    // R4: counters drop on a different consumer set
    cycle(1, 3, 5, 16'h0006, 0, 0, "R4");
    cycle(1, 3, 5, 16'h0050, 0, 0, "R4");
    cycle(0, 0, 0, '0, 1, 3, "R4");
    // R2/R3: another block's traffic leaves block 3 alone
    for (int i = 0; i < 3; i++) cycle(1, 11, 5, 16'h0300, 0, 0, "R2");
    cycle(0, 0, 0, '0, 1, 3, "R3");
    cycle(0, 0, 0, '0, 1, 11, "R3");
    // R8: write and downgrade on the same block in one cycle
    cycle(1, 3, 5, 16'h0050, 1, 3, "R8");
    cycle(1, 3, 9, 16'h8001, 1, 3, "R8");
    cycle(0, 0, 0, '0, 1, 3, "R8");
    // R5: overfill one set so round-robin replacement is used
    for (int i = 0; i < 7; i++) cycle(1, 0, 1, NODES'(16'h0100 << i), 1, 0, "R5");
    for (int i = 0; i < 7; i++) cycle(1, 8, 1, NODES'(16'h0001 << i), 1, 8, "R5");
    // R6: mixed random traffic over a few blocks and patterns
    for (int i = 0; i < 600; i++) begin
      logic [NODES-1:0] pool [4];
      pool[0] = 16'h0050; pool[1] = 16'h0006; pool[2] = 16'h8001; pool[3] = 16'h0000;
      cycle(bit'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(4, 5),
            pool[$urandom_range(0, 3)], bit'($urandom_range(0, 1)),
            $urandom_range(0, 3), "R6");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule